// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Unit

This block holds the four registers that a node acting as isochronous resource manager exposes on a serial bus. They are the bus manager identifier, the remaining isochronous bandwidth, and two 32-bit channel-availability masks. Remote nodes claim and return bus resources by sending compare-swap lock requests. Each request carries an argument and a data value. The block applies a register-specific rule to each request and answers with either the argument or the register's old contents. A 64-bit form of the lock treats both channel masks as a single 64-bit register, so a node can claim channels across both masks in one atomic step.

A packet decoder upstream presents one decoded lock per cycle, as a byte offset, an extended transaction code, a width flag, and the argument and data values. The block acts on the request at the clock edge that captures it and presents a registered response, with a valid strobe, in the following cycle. This makes every read-modify-write atomic with respect to the next request. A bus-reset input puts all four registers back to their power-up allocation. Locks that use an unsupported code, or that target an unsupported register, receive an error code and change nothing.

Top module: `irm_lock_unit`

## Requirements
- R1: After `rst_n` is released, `rsp_valid`, `rsp_code` and `rsp_old` are 0. The registers hold their defaults: bus manager ID 0x3F, bandwidth 4915, channels-high 0xFFFFFFFE, channels-low 0xFFFFFFFF.
- R2: A clock edge with `bus_reset` high restores all four registers to the R1 defaults. A request presented in that same cycle is dropped and produces no response.
- R3: A 32-bit compare-swap (extended code 0x2) at offset 0x21C returns the old bus manager ID. The register takes the data value only when the old value equals the argument.
- R4: At bandwidth offset 0x220, an argument above 0x1FFF returns the old bandwidth and leaves the register unchanged.
- R5: Bandwidth allocation applies when the argument is greater than or equal to data[12:0]. The amount is argument minus data[12:0]. If old >= amount, the register becomes old - amount and the argument is returned. Otherwise the old value is returned and nothing changes.
- R6: Bandwidth release applies when the argument is less than data[12:0]. The amount is data[12:0] minus argument. If old + amount < 0x2000, the register becomes old + amount and the argument is returned. Otherwise the old value is returned. Data bits 31..13 have no effect.
- R7: At channels-high (0x224) and channels-low (0x228), the affected bits are argument XOR data. If the argument and the register agree on every affected bit, the register is XORed with the affected bits and the argument is returned. Otherwise the current register is returned unchanged.
- R8: Data bit 0 of a channels-high lock, which is bit 32 of a 64-bit lock, is forced to 0 before use. As a result, bit 0 of channels-high always stays 0.
- R9: A 64-bit lock (`req_wide`=1) at 0x224 applies the R7 rule to {channels-high, channels-low}, with channels-high in bits 63..32, as one operation. It returns the 64-bit argument or the 64-bit old value.
- R10: Response codes are 0 done, 1 type error and 2 address error. The following return a type error:
  - a misaligned offset;
  - any non-0x2 code at 0x21C..0x228;
  - a 64-bit lock at 0x21C, 0x220 or 0x228;
  - any lock at 0x000, 0x004, 0x008, 0x00C, 0x018, 0x01C, 0x200, 0x204 or 0x234.
  All other offsets return an address error. An error response carries `rsp_old`=0 and changes no register.
- R11: `rsp_valid` is high in exactly the cycle after each request captured without `bus_reset`, and is low otherwise. For 32-bit locks, `rsp_old` bits 63..32 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous restore of the resource defaults |
| req_valid | input | 1 | A lock request is present this cycle |
| req_wide | input | 1 | 1 selects a 64-bit lock, 0 a 32-bit lock |
| req_addr | input | ADDR_W (12) | Byte offset within the register space |
| req_ext | input | EXT_W (4) | Extended transaction code |
| req_arg | input | 2*QW (64) | Argument value; 32-bit locks use bits 31..0 |
| req_data | input | 2*QW (64) | Data value; 32-bit locks use bits 31..0 |
| rsp_valid | output | 1 | Response strobe, one cycle per request |
| rsp_code | output | 2 | 0 done, 1 type error, 2 address error |
| rsp_old | output | 2*QW (64) | Returned argument or old value; 0 on error |

## Verification
The assertions check the cycle-level rules on every cycle:
- the response strobe follows each accepted request by one cycle and stays quiet otherwise;
- bus reset restores the defaults;
- channel 31 in channels-high never becomes free;
- an error response carries a zero value and leaves all four registers untouched.

The bench's sweeps cover the arithmetic: the exact allocation and release boundaries of the bandwidth register, the agree-or-reject outcome of the channel toggling in both widths, masking of the upper data bits, and the full map of codes and offsets to error classes. These are checked against values the bench computes for itself.

// File: rtl/irm_pkg.sv
package irm_pkg;

   typedef enum logic [1:0] {
      RSP_DONE = 2'b00,
      RSP_TYPE = 2'b01,
      RSP_ADDR = 2'b10
   } rsp_e;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_BMID = 3'd1,
      OP_BW   = 3'd2,
      OP_CHH  = 3'd3,
      OP_CHL  = 3'd4,
      OP_CH64 = 3'd5
   } op_e;

   // implemented control registers that never accept a lock
   localparam int N_CTRL = 9;
   localparam logic [15:0] CTRL_OFFS [N_CTRL] = '{
      16'h000, 16'h004, 16'h008, 16'h00C, 16'h018,
      16'h01C, 16'h200, 16'h204, 16'h234
   };

endpackage

// File: rtl/irm_lock_decode.sv
module irm_lock_decode
   import irm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int EXT_W = 4,
   parameter logic [ADDR_W-1:0] IRM_BASE = 'h21C,
   parameter logic [EXT_W-1:0] CSWAP_CODE = 'h2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wide,
   input  logic [EXT_W-1:0]  ext,
   output op_e               op,
   output rsp_e              code
);
   localparam logic [ADDR_W-1:0] WINDOW = ADDR_W'(16);
   localparam logic [ADDR_W-1:0] CHH_REL = ADDR_W'(8);

   logic [ADDR_W-1:0] off;
   logic              aligned;
   logic              in_irm;
   logic              is_cswap;
   logic [N_CTRL-1:0] ctrl_hit;

   assign off      = addr - IRM_BASE;
   assign aligned  = (addr[1:0] == 2'b00);
   assign in_irm   = (off < WINDOW);
   assign is_cswap = (ext == CSWAP_CODE);

   for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
      assign ctrl_hit[i] = (addr == CTRL_OFFS[i][ADDR_W-1:0]);
   end

   always_comb begin
      op   = OP_NONE;
      code = RSP_ADDR;
      if (!aligned) begin
         code = RSP_TYPE;
      end else if (!wide && in_irm) begin
         if (is_cswap) begin
            code = RSP_DONE;
            case (off[3:2])
               2'd0:    op = OP_BMID;
               2'd1:    op = OP_BW;
               2'd2:    op = OP_CHH;
               default: op = OP_CHL;
            endcase
         end else begin
            code = RSP_TYPE;
         end
      end else if (wide && off == CHH_REL) begin
         if (is_cswap) begin
            code = RSP_DONE;
            op   = OP_CH64;
         end else begin
            code = RSP_TYPE;
         end
      end else if (in_irm || (|ctrl_hit)) begin
         code = RSP_TYPE;
      end
   end

endmodule

// File: rtl/irm_bw_cas.sv
module irm_bw_cas #(
   parameter int QW = 32,
   parameter int BW_W = 13
) (
   input  logic [BW_W-1:0] cur,
   input  logic [QW-1:0]   arg,
   input  logic [BW_W-1:0] data,
   output logic [BW_W-1:0] nxt,
   output logic [QW-1:0]   ret,
   output logic            upd
);
   logic            arg_big;
   logic [BW_W-1:0] a;
   logic [BW_W-1:0] amt;
   logic [BW_W:0]   sum;

   assign arg_big = |arg[QW-1:BW_W];
   assign a       = arg[BW_W-1:0];

   always_comb begin
      nxt = cur;
      upd = 1'b0;
      ret = QW'(cur);
      amt = '0;
      sum = '0;
      if (!arg_big) begin
         if (a >= data) begin
            amt = a - data;
            if (cur >= amt) begin
               nxt = cur - amt;
               upd = 1'b1;
               ret = arg;
            end
         end else begin
            amt = data - a;
            sum = {1'b0, cur} + {1'b0, amt};
            if (!sum[BW_W]) begin
               nxt = sum[BW_W-1:0];
               upd = 1'b1;
               ret = arg;
            end
         end
      end
   end

endmodule

// File: rtl/irm_chan_cas.sv
module irm_chan_cas #(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] arg,
   input  logic [W-1:0] data,
   output logic [W-1:0] nxt,
   output logic [W-1:0] ret,
   output logic         hit
);
   logic [W-1:0] flip;

   assign flip = arg ^ data;
   assign hit  = ((arg & flip) == (cur & flip));
   assign nxt  = cur ^ flip;
   assign ret  = hit ? arg : cur;

endmodule

// File: rtl/irm_lock_unit.sv
module irm_lock_unit
   import irm_pkg::*;
#(
   parameter int QW = 32,
   parameter int BW_W = 13,
   parameter int ADDR_W = 12,
   parameter int EXT_W = 4,
   parameter logic [ADDR_W-1:0] IRM_BASE = 'h21C,
   parameter logic [EXT_W-1:0] CSWAP_CODE = 'h2,
   parameter logic [QW-1:0] BMID_RESET = 'h3F,
   parameter int BW_RESET = 4915,
   parameter logic [QW-1:0] CHH_RESET = 'hFFFF_FFFE,
   parameter logic [QW-1:0] CHL_RESET = 'hFFFF_FFFF,
   parameter bit PROTECT_CH_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              req_valid,
   input  logic              req_wide,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [EXT_W-1:0]  req_ext,
   input  logic [2*QW-1:0]   req_arg,
   input  logic [2*QW-1:0]   req_data,
   output logic              rsp_valid,
   output logic [1:0]        rsp_code,
   output logic [2*QW-1:0]   rsp_old
);
   localparam int DW = 2 * QW;
   localparam logic [BW_W-1:0] BW_INIT = BW_W'(BW_RESET);

   // elaboration-time parameter checks
   if (BW_W < 2 || BW_W >= QW) begin : g_bad_bw
      $error("irm_lock_unit: BW_W must lie in 2..QW-1");
   end
   if (BW_RESET < 0 || BW_RESET >= (1 << BW_W)) begin : g_bad_bw_reset
      $error("irm_lock_unit: BW_RESET does not fit in BW_W bits");
   end
   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
      $error("irm_lock_unit: ADDR_W must lie in 8..16");
   end
   if (IRM_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("irm_lock_unit: IRM_BASE must be quadlet aligned");
   end

   // architectural state
   logic [QW-1:0]   bmid_q;
   logic [BW_W-1:0] bw_q;
   logic [QW-1:0]   chh_q;
   logic [QW-1:0]   chl_q;

   // decode
   op_e  dec_op;
   rsp_e dec_code;

   irm_lock_decode #(
      .ADDR_W     (ADDR_W),
      .EXT_W      (EXT_W),
      .IRM_BASE   (IRM_BASE),
      .CSWAP_CODE (CSWAP_CODE)
   ) u_decode (
      .addr (req_addr),
      .wide (req_wide),
      .ext  (req_ext),
      .op   (dec_op),
      .code (dec_code)
   );

   // guard mask that keeps the top channel permanently allocated
   logic [QW-1:0] guard;
   if (PROTECT_CH_TOP) begin : g_guard_on
      assign guard = {{(QW-1){1'b1}}, 1'b0};
   end else begin : g_guard_off
      assign guard = '1;
   end

   logic [QW-1:0] arg_lo;
   logic [QW-1:0] data_lo;
   assign arg_lo  = req_arg[QW-1:0];
   assign data_lo = req_data[QW-1:0];

   // bus manager ID: plain compare-swap
   logic bmid_hit;
   assign bmid_hit = (bmid_q == arg_lo);

   // bandwidth
   logic [BW_W-1:0] bw_nxt;
   logic [QW-1:0]   bw_ret;
   logic            bw_upd;

   irm_bw_cas #(
      .QW   (QW),
      .BW_W (BW_W)
   ) u_bw (
      .cur  (bw_q),
      .arg  (arg_lo),
      .data (data_lo[BW_W-1:0]),
      .nxt  (bw_nxt),
      .ret  (bw_ret),
      .upd  (bw_upd)
   );

   // single channel register
   logic [QW-1:0] cs_cur;
   logic [QW-1:0] cs_data;
   logic [QW-1:0] cs_nxt;
   logic [QW-1:0] cs_ret;
   logic          cs_hit;

   assign cs_cur  = (dec_op == OP_CHL) ? chl_q : chh_q;
   assign cs_data = (dec_op == OP_CHH) ? (data_lo & guard) : data_lo;

   irm_chan_cas #(
      .W (QW)
   ) u_chan_single (
      .cur  (cs_cur),
      .arg  (arg_lo),
      .data (cs_data),
      .nxt  (cs_nxt),
      .ret  (cs_ret),
      .hit  (cs_hit)
   );

   // both channel registers as one
   logic [DW-1:0] cw_cur;
   logic [DW-1:0] cw_data;
   logic [DW-1:0] cw_nxt;
   logic [DW-1:0] cw_ret;
   logic          cw_hit;

   assign cw_cur  = {chh_q, chl_q};
   assign cw_data = {req_data[DW-1:QW] & guard, data_lo};

   irm_chan_cas #(
      .W (DW)
   ) u_chan_wide (
      .cur  (cw_cur),
      .arg  (req_arg),
      .data (cw_data),
      .nxt  (cw_nxt),
      .ret  (cw_ret),
      .hit  (cw_hit)
   );

   // response value
   logic [DW-1:0] ret_val;
   always_comb begin
      case (dec_op)
         OP_BMID:        ret_val = DW'(bmid_q);
         OP_BW:          ret_val = DW'(bw_ret);
         OP_CHH, OP_CHL: ret_val = DW'(cs_ret);
         OP_CH64:        ret_val = cw_ret;
         default:        ret_val = '0;
      endcase
   end

   // state and response registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bmid_q    <= BMID_RESET;
         bw_q      <= BW_INIT;
         chh_q     <= CHH_RESET;
         chl_q     <= CHL_RESET;
         rsp_valid <= 1'b0;
         rsp_code  <= 2'b00;
         rsp_old   <= '0;
      end else if (bus_reset) begin
         bmid_q    <= BMID_RESET;
         bw_q      <= BW_INIT;
         chh_q     <= CHH_RESET;
         chl_q     <= CHL_RESET;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_code <= dec_code;
            rsp_old  <= ret_val;
            case (dec_op)
               OP_BMID: if (bmid_hit) bmid_q <= data_lo;
               OP_BW:   if (bw_upd)   bw_q   <= bw_nxt;
               OP_CHH:  if (cs_hit)   chh_q  <= cs_nxt;
               OP_CHL:  if (cs_hit)   chl_q  <= cs_nxt;
               OP_CH64: if (cw_hit)   {chh_q, chl_q} <= cw_nxt;
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/irm_lock_unit_chk.sv
module irm_lock_unit_chk #(
   parameter int QW = 32,
   parameter int BW_W = 13,
   parameter int BW_RESET = 4915,
   parameter logic [QW-1:0] BMID_RESET = 'h3F,
   parameter logic [QW-1:0] CHH_RESET = 'hFFFF_FFFE,
   parameter logic [QW-1:0] CHL_RESET = 'hFFFF_FFFF,
   parameter bit PROTECT_CH_TOP = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_reset,
   input logic            req_valid,
   input logic            rsp_valid,
   input logic [1:0]      rsp_code,
   input logic [2*QW-1:0] rsp_old,
   input logic [1:0]      dec_code,
   input logic [QW-1:0]   bmid_q,
   input logic [BW_W-1:0] bw_q,
   input logic [QW-1:0]   chh_q,
   input logic [QW-1:0]   chl_q
);

   a_r11_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !bus_reset) |=> rsp_valid);

   a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || bus_reset) |=> !rsp_valid);

   a_r2_defaults_restored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (bmid_q == BMID_RESET && bw_q == BW_W'(BW_RESET)
                     && chh_q == CHH_RESET && chl_q == CHL_RESET));

   a_r10_error_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !bus_reset && dec_code != 2'b00) |=>
      ($stable(bmid_q) && $stable(bw_q) && $stable(chh_q) && $stable(chl_q)));

   a_r10_error_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != 2'b00) |-> (rsp_old == '0));

   if (PROTECT_CH_TOP) begin : g_prot
      a_r8_top_channel_kept: assert property (@(posedge clk) disable iff (!rst_n)
         chh_q[0] == 1'b0);
   end

endmodule

bind irm_lock_unit irm_lock_unit_chk #(
   .QW             (QW),
   .BW_W           (BW_W),
   .BW_RESET       (BW_RESET),
   .BMID_RESET     (BMID_RESET),
   .CHH_RESET      (CHH_RESET),
   .CHL_RESET      (CHL_RESET),
   .PROTECT_CH_TOP (PROTECT_CH_TOP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_reset (bus_reset),
   .req_valid (req_valid),
   .rsp_valid (rsp_valid),
   .rsp_code  (rsp_code),
   .rsp_old   (rsp_old),
   .dec_code  (dec_code),
   .bmid_q    (bmid_q),
   .bw_q      (bw_q),
   .chh_q     (chh_q),
   .chl_q     (chl_q)
);

// File: tb/irm_lock_unit_bench.sv
`timescale 1ns/1ps
module irm_lock_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_reset = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_wide = 1'b0;
   logic [11:0] req_addr = '0;
   logic [3:0]  req_ext = '0;
   logic [63:0] req_arg = '0;
   logic [63:0] req_data = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_code;
   logic [63:0] rsp_old;

   always #2.5 clk = ~clk;

   irm_lock_unit u_irm_lock_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_reset (bus_reset),
      .req_valid (req_valid),
      .req_wide  (req_wide),
      .req_addr  (req_addr),
      .req_ext   (req_ext),
      .req_arg   (req_arg),
      .req_data  (req_data),
      .rsp_valid (rsp_valid),
      .rsp_code  (rsp_code),
      .rsp_old   (rsp_old)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit reported = 1'b0;

   // reference state
   logic [31:0] m_bmid, m_chh, m_chl;
   int          m_bw;

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   task automatic model_defaults();
      m_bmid = 32'h3F;
      m_bw   = 4915;
      m_chh  = 32'hFFFF_FFFE;
      m_chl  = 32'hFFFF_FFFF;
   endtask

   function automatic bit is_ctrl(input logic [11:0] a);
      return a == 12'h000 || a == 12'h004 || a == 12'h008 || a == 12'h00C ||
             a == 12'h018 || a == 12'h01C || a == 12'h200 || a == 12'h204 ||
             a == 12'h234;
   endfunction

   // reference model: computes expected code/value and updates state (R3..R10)
   task automatic model(input bit wide, input logic [11:0] a, input logic [3:0] e,
                        input logic [63:0] arg, input logic [63:0] data,
                        output logic [1:0] code, output logic [63:0] old);
      bit in_irm;
      in_irm = (a >= 12'h21C && a <= 12'h228);
      old = '0;
      if (a[1:0] != 2'b00) code = 2'd1;
      else if (!wide && in_irm && e == 4'h2) code = 2'd0;
      else if (wide && a == 12'h224 && e == 4'h2) code = 2'd0;
      else if (in_irm || is_ctrl(a)) code = 2'd1;
      else code = 2'd2;
      if (code != 2'd0) return;
      if (wide) begin
         logic [63:0] cur, d, fl;
         cur = {m_chh, m_chl};
         d = data;
         d[32] = 1'b0;
         fl = arg ^ d;
         if ((arg & fl) == (cur & fl)) begin
            cur = cur ^ fl;
            old = arg;
            {m_chh, m_chl} = cur;
         end else old = cur;
      end else if (a == 12'h21C) begin
         old = {32'h0, m_bmid};
         if (m_bmid == arg[31:0]) m_bmid = data[31:0];
      end else if (a == 12'h220) begin
         longint av, dv, amt;
         av = longint'(arg[31:0]);
         dv = longint'(data[12:0]);
         old = 64'(m_bw);
         if (av <= 8191) begin
            if (av >= dv) begin
               amt = av - dv;
               if (longint'(m_bw) >= amt) begin
                  m_bw = int'(longint'(m_bw) - amt);
                  old = 64'(av);
               end
            end else begin
               amt = dv - av;
               if (longint'(m_bw) + amt < 8192) begin
                  m_bw = int'(longint'(m_bw) + amt);
                  old = 64'(av);
               end
            end
         end
      end else begin
         logic [31:0] cur, d, fl;
         cur = (a == 12'h224) ? m_chh : m_chl;
         d = data[31:0];
         if (a == 12'h224) d[0] = 1'b0;
         fl = arg[31:0] ^ d;
         if ((arg[31:0] & fl) == (cur & fl)) begin
            cur = cur ^ fl;
            old = {32'h0, arg[31:0]};
         end else old = {32'h0, cur};
         if (a == 12'h224) m_chh = cur; else m_chl = cur;
      end
   endtask

   task automatic lock(input bit wide, input logic [11:0] a, input logic [3:0] e,
                       input logic [63:0] arg, input logic [63:0] data, input string tag);
      logic [1:0]  ec;
      logic [63:0] eo;
      model(wide, a, e, arg, data, ec, eo);
      @(negedge clk);
      req_valid = 1'b1;
      req_wide  = wide;
      req_addr  = a;
      req_ext   = e;
      req_arg   = arg;
      req_data  = data;
      @(posedge clk);
      #1;
      n_cmp++;
      if (rsp_valid !== 1'b1 || rsp_code !== ec || rsp_old !== eo) begin
         n_bad++;
         $display("FAIL %s addr=%h wide=%0d: valid=%b code=%0d old=%h, expected valid=1 code=%0d old=%h",
                  tag, a, wide, rsp_valid, rsp_code, rsp_old, ec, eo);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_quiet(input string tag);
      n_cmp++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: rsp_valid=%b, expected 0", tag, rsp_valid);
      end
   endtask

   // reads each register back through locks that cannot succeed (or are modelled if they do)
   task automatic read_all(input string tag);
      lock(1'b0, 12'h21C, 4'h2, 64'hFFFF_FFFF, 64'h0, tag);
      lock(1'b0, 12'h220, 4'h2, 64'hFFFF_FFFF, 64'h0, tag);
      lock(1'b0, 12'h224, 4'h2, 64'h0, 64'hFFFF_FFFF, tag);
      lock(1'b0, 12'h228, 4'h2, 64'h0, 64'hFFFF_FFFF, tag);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
      $finish;
   end

   initial begin
      model_defaults();
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if (rsp_valid !== 1'b0 || rsp_code !== 2'b00 || rsp_old !== 64'h0) begin
         n_bad++;
         $display("FAIL R1: valid=%b code=%0d old=%h, expected 0 0 0", rsp_valid, rsp_code, rsp_old);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      expect_quiet("R11");

      // R1: defaults visible through the lock interface
      read_all("R1");

      // R3: bus manager ID sweep
      for (int i = 0; i < 64; i++) begin
         logic [31:0] arg;
         arg = (i % 2 == 0) ? m_bmid : $urandom;
         lock(1'b0, 12'h21C, 4'h2, {$urandom, arg}, {$urandom, 26'h0, 6'(i)}, "R3");
      end

      // R4/R5/R6: bandwidth sweep around the limits
      for (int i = 0; i < 600; i++) begin
         logic [31:0] arg, data;
         int sel;
         sel = $urandom % 7;
         arg = $urandom % 8192;
         data = {$urandom, 13'h0} | ($urandom % 8192);
         case (sel)
            0: arg = 32'h2000 + ($urandom % 16);                       // R4 just over
            1: arg = $urandom | 32'h8000_0000;                        // R4 far over
            2: begin                                                  // R5 exact drain
               arg = 32'(m_bw) + ($urandom % (8192 - m_bw));
               data[12:0] = 13'(arg - 32'(m_bw));
            end
            3: begin                                                  // R5 one too many
               arg = 32'h1FFF;
               data[12:0] = 13'(32'h1FFF - 32'(m_bw) - 1);
               if (m_bw == 8191) data[12:0] = 13'h0;
            end
            4: begin                                                  // R6 up to the ceiling
               arg = $urandom % 64;
               data[12:0] = 13'(arg + 32'(8191 - m_bw) + (i % 2));
               if (arg + 32'(8191 - m_bw) + 32'(i % 2) > 32'h1FFF) data[12:0] = 13'h1FFF;
            end
            default: ;
         endcase
         lock(1'b0, 12'h220, 4'h2, {$urandom, arg}, {$urandom, data},
              sel < 2 ? "R4" : (sel == 4 ? "R6" : "R5"));
      end

      // R7/R8: single channel registers
      for (int i = 0; i < 400; i++) begin
         logic [11:0] a;
         logic [31:0] cur, arg, data;
         a = (i % 2 == 0) ? 12'h224 : 12'h228;
         cur = (a == 12'h224) ? m_chh : m_chl;
         arg = (i % 3 == 0) ? (cur ^ ($urandom & $urandom & $urandom)) : cur;
         data = arg ^ ($urandom & $urandom);
         if (i % 7 == 0) begin                                        // release attempt on channel 31
            a = 12'h224;
            arg = m_chh | ((i % 14 == 0) ? 32'h1 : 32'h0);
            data = arg | 32'h1;
         end
         lock(1'b0, a, 4'h2, {$urandom, arg}, {$urandom, data}, (i % 7 == 0) ? "R8" : "R7");
      end

      // R9: 64-bit locks
      for (int i = 0; i < 200; i++) begin
         logic [63:0] cur, arg, data;
         cur = {m_chh, m_chl};
         arg = (i % 3 == 0) ? (cur ^ {$urandom & $urandom, $urandom & $urandom}) : cur;
         data = arg ^ {$urandom & $urandom, $urandom & $urandom};
         if (i % 5 == 0) data[32] = 1'b1;
         lock(1'b1, 12'h224, 4'h2, arg, data, (i % 5 == 0) ? "R8" : "R9");
      end
      read_all("R9");

      // R10: codes, offsets and widths
      for (int e = 0; e < 16; e++) begin
         for (int r = 0; r < 4; r++) begin
            lock(1'b0, 12'h21C + 12'(4 * r), 4'(e), {$urandom, $urandom}, {$urandom, $urandom}, "R10");
            lock(1'b1, 12'h21C + 12'(4 * r), 4'(e), {$urandom, $urandom}, {$urandom, $urandom}, "R10");
         end
      end
      begin
         logic [11:0] offs [14];
         offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h018, 12'h01C, 12'h200,
                  12'h204, 12'h234, 12'h010, 12'h210, 12'h22C, 12'h300, 12'hFFC};
         for (int k = 0; k < 14; k++) begin
            lock(1'b0, offs[k], 4'h2, {$urandom, $urandom}, {$urandom, $urandom}, "R10");
            lock(1'b1, offs[k], 4'h2, {$urandom, $urandom}, {$urandom, $urandom}, "R10");
         end
      end
      for (int k = 1; k < 4; k++) begin
         lock(1'b0, 12'h220 + 12'(k), 4'h2, 64'h0, 64'h5, "R10");
         lock(1'b1, 12'h224 + 12'(k), 4'h2, 64'h0, 64'h5, "R10");
      end
      read_all("R10");

      // R2: bus reset with a colliding request
      lock(1'b0, 12'h21C, 4'h2, {32'h0, m_bmid}, 64'h11, "R3");
      @(negedge clk);
      bus_reset = 1'b1;
      req_valid = 1'b1;
      req_wide  = 1'b0;
      req_addr  = 12'h21C;
      req_ext   = 4'h2;
      req_arg   = {32'h0, m_bmid};
      req_data  = 64'h22;
      @(posedge clk);
      #1;
      expect_quiet("R2");
      @(negedge clk);
      bus_reset = 1'b0;
      req_valid = 1'b0;
      model_defaults();
      @(posedge clk);
      #1;
      expect_quiet("R11");
      read_all("R2");

      report();
      $finish;
   end

endmodule